// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small eight-bit accumulator machine. It holds the accumulator and a five-bit flag register: sign, zero, half carry, parity and carry. Each cycle it can accept one operation, which takes a code and an eight-bit second operand. The operation combines the accumulator, the operand and the current flags, and writes the new accumulator and flags on the next rising clock edge. A separate sixteen-bit pair add takes two sixteen-bit inputs, registers their sum and reports the overflow in the carry flag.

Operations enter as a one-cycle stream item qualified by `op_valid`. The unit has no back-pressure, so there is no ready signal: every cycle with `op_valid` high consumes exactly one operation. Each operation group writes its own subset of the flags. The decimal-adjust operation uses the half-carry and carry flags to correct the accumulator into packed two-digit BCD after a BCD addition.

Top module: `alu8_acc_core`

## Requirements
- R1: `rst` is synchronous and dominates `op_valid`. A rising edge with `rst` high clears `acc_q`, `flags_q` and `pair_q` to zero.
- R2: When `op_valid` is low, or the operation code is 19 to 31, no register changes at the edge.
- R3: Code 0 (add) writes A+B and code 1 (add with carry) writes A+B+CY. CY is the carry out of bit 7, and the half-carry flag is the carry out of bit 3.
- R4: Code 2 (subtract) writes A-B and code 3 (subtract with borrow) writes A-B-CY. CY is set when the true difference is negative. The half-carry flag is set when the low-nibble difference, with the borrow in, is negative.
- R5: Codes 4, 5 and 6 write A AND B, A OR B and A XOR B. Each clears both CY and the half-carry flag.
- R6: Code 7 (compare) leaves A unchanged and sets the flags as a subtract would. A>B gives CY=0 and Z=0, A=B gives CY=0 and Z=1, and A<B gives CY=1 and Z=0.
- R7: `flags_q` bit 4 is sign, bit 3 zero, bit 2 half carry, bit 1 parity and bit 0 carry. For codes 0 to 9 and 17, sign is result bit 7, zero is set when the eight-bit result is 0, and parity is set when the result has an even number of ones.
- R8: Code 8 (increment) and code 9 (decrement) change A by one and keep the previous CY. The half-carry flag is set on a low-nibble carry (increment) or a low-nibble borrow (decrement).
- R9: Codes 11 to 14 rotate A by one bit and change only CY. Code 11 rotates left with bit 7 going to bit 0 and to CY. Code 12 rotates right with bit 0 going to bit 7 and to CY. Code 13 rotates left through carry, with CY going into bit 0 and bit 7 into CY. Code 14 rotates right through carry, with CY going into bit 7 and bit 0 into CY.
- R10: Code 10 inverts A and leaves every flag unchanged. Code 15 sets CY to 1 and code 16 inverts CY. Neither code 15 nor code 16 changes any other flag or A.
- R11: Code 17 (decimal adjust) adds 6 when the low nibble exceeds 9 or the half-carry flag is set. It then adds 0x60 when the resulting high nibble exceeds 9, when CY is set, or when the first step overflowed. The new CY is that second decision, and the new half-carry flag is the low-nibble carry of the first step. For example, 0x39+0x12 gives 0x4B, which adjusts to 0x51.
- R12: Code 18 (pair add) registers `pair_hl`+`pair_rp` in `pair_q` and sets CY to bit 16 of the sum. A and the other four flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| operand | input | DATA_W | Second eight-bit operand B |
| pair_hl | input | 2*DATA_W | First addend of the pair add |
| pair_rp | input | 2*DATA_W | Second addend of the pair add |
| acc_q | output | DATA_W | Accumulator |
| flags_q | output | 5 | {sign, zero, half carry, parity, carry} |
| pair_q | output | 2*DATA_W | Registered result of the last pair add |

## Verification
The bench builds the unit with its default DATA_W of 8. At that width the whole 256-value accumulator range can be swept for every operation, with both carry-in values. The sweeps combine each binary operation with operands that hit zero, nibble-boundary, all-ones and equal-to-A cases. Decimal adjust is driven from real additions across all accumulator values, so every half-carry, carry and overflow combination of its two decisions is reached. A pseudo-random stream then mixes idle cycles, undefined codes and pair adds against a bench-side arithmetic model of the accumulator and flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBB = 5'd3,
    OP_AND = 5'd4,
    OP_OR  = 5'd5,
    OP_XOR = 5'd6,
    OP_CMP = 5'd7,
    OP_INC = 5'd8,
    OP_DEC = 5'd9,
    OP_CMA = 5'd10,
    OP_RLC = 5'd11,
    OP_RRC = 5'd12,
    OP_RAL = 5'd13,
    OP_RAR = 5'd14,
    OP_STC = 5'd15,
    OP_CMC = 5'd16,
    OP_DAA = 5'd17,
    OP_DAD = 5'd18
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
// Shared adder/subtractor with carry (borrow) out of the top bit and of the low nibble.
module alu8_addsub #(
  parameter int W  = 8,
  parameter int HW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         hcout
);
  logic [W:0]  full;
  logic [HW:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      half = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - {{HW{1'b0}}, cin};
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      half = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
    end
  end

  assign res   = full[W-1:0];
  assign cout  = full[W];
  assign hcout = half[HW];
endmodule

// File: rtl/alu8_rotate.sv
// One-bit rotate, plain or through carry, in either direction.
module alu8_rotate #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cy_in,
  input  logic         right,
  input  logic         thru,
  output logic [W-1:0] res,
  output logic         cy_out
);
  logic fill;

  always_comb begin
    if (!right) begin
      fill   = thru ? cy_in : a[W-1];
      res    = {a[W-2:0], fill};
      cy_out = a[W-1];
    end else begin
      fill   = thru ? cy_in : a[0];
      res    = {fill, a[W-1:1]};
      cy_out = a[0];
    end
  end
endmodule

// File: rtl/alu8_decadj.sv
// Packed two-digit BCD correction driven by half carry and carry.
module alu8_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         ac_in,
  input  logic         cy_in,
  output logic [W-1:0] res,
  output logic         ac_out,
  output logic         cy_out
);
  localparam int HW = W / 2;
  localparam logic [HW-1:0] NINE = HW'(9);
  localparam logic [HW-1:0] SIX  = HW'(6);

  logic          lo_fix, hi_fix;
  logic [HW:0]   lo_sum;
  logic [W:0]    stage1;

  always_comb begin
    lo_fix = (a[HW-1:0] > NINE) | ac_in;
    lo_sum = {1'b0, a[HW-1:0]} + {1'b0, (lo_fix ? SIX : {HW{1'b0}})};
    stage1 = {1'b0, a} + {{(W+1-HW){1'b0}}, (lo_fix ? SIX : {HW{1'b0}})};
    hi_fix = (stage1[W-1:HW] > NINE) | cy_in | stage1[W];
    res    = stage1[W-1:0] + (hi_fix ? {SIX, {HW{1'b0}}} : {W{1'b0}});
    ac_out = lo_sum[HW];
    cy_out = hi_fix;
  end
endmodule

// File: rtl/alu8_acc_core.sv
module alu8_acc_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAIR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  input  logic [PAIR_W-1:0] pair_hl,
  input  logic [PAIR_W-1:0] pair_rp,
  output logic [DATA_W-1:0] acc_q,
  output logic [4:0]        flags_q,
  output logic [PAIR_W-1:0] pair_q
);
  localparam int HW = DATA_W / 2;

  alu_op_e    op;
  alu_flags_t fl;
  assign op = alu_op_e'(op_code);
  assign fl = alu_flags_t'(flags_q);

  // adder operand steering
  logic              as_sub, as_cin;
  logic [DATA_W-1:0] as_b, as_res;
  logic              as_cout, as_hcout;

  always_comb begin
    as_sub = 1'b0;
    as_cin = 1'b0;
    as_b   = operand;
    case (op)
      OP_ADC: as_cin = fl.cy;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBB: begin as_sub = 1'b1; as_cin = fl.cy; end
      OP_INC: begin as_b = '0; as_cin = 1'b1; end
      OP_DEC: begin as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(DATA_W), .HW(HW)) u_addsub (
    .a(acc_q), .b(as_b), .cin(as_cin), .sub(as_sub),
    .res(as_res), .cout(as_cout), .hcout(as_hcout)
  );

  logic [DATA_W-1:0] rot_res;
  logic              rot_cy;
  logic [4:0]        rot_sel;
  assign rot_sel = op_code - 5'd11;

  alu8_rotate #(.W(DATA_W)) u_rot (
    .a(acc_q), .cy_in(fl.cy), .right(rot_sel[0]), .thru(rot_sel[1]),
    .res(rot_res), .cy_out(rot_cy)
  );

  logic [DATA_W-1:0] daa_res;
  logic              daa_ac, daa_cy;

  alu8_decadj #(.W(DATA_W)) u_daa (
    .a(acc_q), .ac_in(fl.ac), .cy_in(fl.cy),
    .res(daa_res), .ac_out(daa_ac), .cy_out(daa_cy)
  );

  logic [PAIR_W:0] pair_sum;
  assign pair_sum = {1'b0, pair_hl} + {1'b0, pair_rp};

  // result selection and flag update
  logic [DATA_W-1:0] nxt_acc, flag_src;
  alu_flags_t        nxt_fl;
  logic [PAIR_W-1:0] nxt_pair;
  logic              szp_upd;

  always_comb begin
    nxt_acc  = acc_q;
    nxt_fl   = fl;
    nxt_pair = pair_q;
    flag_src = as_res;
    szp_upd  = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        nxt_acc   = as_res;
        nxt_fl.cy = as_cout;
        nxt_fl.ac = as_hcout;
        szp_upd   = 1'b1;
      end
      OP_CMP: begin
        nxt_fl.cy = as_cout;
        nxt_fl.ac = as_hcout;
        szp_upd   = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        case (op)
          OP_AND:  flag_src = acc_q & operand;
          OP_OR:   flag_src = acc_q | operand;
          default: flag_src = acc_q ^ operand;
        endcase
        nxt_acc   = flag_src;
        nxt_fl.cy = 1'b0;
        nxt_fl.ac = 1'b0;
        szp_upd   = 1'b1;
      end
      OP_INC, OP_DEC: begin
        nxt_acc   = as_res;
        nxt_fl.ac = as_hcout;
        szp_upd   = 1'b1;
      end
      OP_CMA: nxt_acc = ~acc_q;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        nxt_acc   = rot_res;
        nxt_fl.cy = rot_cy;
      end
      OP_STC: nxt_fl.cy = 1'b1;
      OP_CMC: nxt_fl.cy = ~fl.cy;
      OP_DAA: begin
        flag_src  = daa_res;
        nxt_acc   = daa_res;
        nxt_fl.ac = daa_ac;
        nxt_fl.cy = daa_cy;
        szp_upd   = 1'b1;
      end
      OP_DAD: begin
        nxt_pair  = pair_sum[PAIR_W-1:0];
        nxt_fl.cy = pair_sum[PAIR_W];
      end
      default: ;
    endcase
    if (szp_upd) begin
      nxt_fl.s = flag_src[DATA_W-1];
      nxt_fl.z = (flag_src == '0);
      nxt_fl.p = ~^flag_src;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      flags_q <= '0;
      pair_q  <= '0;
    end else if (op_valid) begin
      acc_q   <= nxt_acc;
      flags_q <= nxt_fl;
      pair_q  <= nxt_pair;
    end
  end
endmodule

// File: rtl/alu8_acc_checker.sv
module alu8_acc_checker
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [4:0]        op_code,
  input logic [DATA_W-1:0] acc_q,
  input logic [4:0]        flags_q
);
  logic szp_op, rot_op;
  assign szp_op = (op_code <= OP_DEC) || (op_code == OP_DAA);
  assign rot_op = (op_code >= OP_RLC) && (op_code <= OP_RAR);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && (flags_q == '0)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_code > OP_DAD) |=> $stable(acc_q) && $stable(flags_q)); // R2

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMP) |=> $stable(acc_q)); // R6

  AST_SZP_FROM_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && szp_op && op_code != OP_CMP) |=>
      (flags_q[4] == acc_q[DATA_W-1]) && (flags_q[3] == (acc_q == '0)) &&
      (flags_q[1] == ~^acc_q)); // R7

  AST_INCDEC_KEEPS_CY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_INC || op_code == OP_DEC)) |=>
      flags_q[0] == $past(flags_q[0])); // R8

  AST_ROT_ONLY_CY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && rot_op) |=> flags_q[4:1] == $past(flags_q[4:1])); // R9

  AST_CMA_INVERTS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMA) |=>
      (acc_q == ~$past(acc_q)) && $stable(flags_q)); // R10

  AST_STC_SETS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_STC) |=> flags_q[0] && $stable(acc_q)); // R10

  AST_DAD_ONLY_CY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_DAD) |=>
      $stable(acc_q) && flags_q[4:1] == $past(flags_q[4:1])); // R12
endmodule

bind alu8_acc_core alu8_acc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .acc_q(acc_q), .flags_q(flags_q)
);

// File: tb/tb_alu8_acc_core.sv
module tb_alu8_acc_core;
  localparam logic [4:0] C_ADD = 5'd0,  C_ADC = 5'd1,  C_SUB = 5'd2,  C_SBB = 5'd3;
  localparam logic [4:0] C_AND = 5'd4,  C_OR  = 5'd5,  C_XOR = 5'd6,  C_CMP = 5'd7;
  localparam logic [4:0] C_INC = 5'd8,  C_DEC = 5'd9,  C_CMA = 5'd10, C_RLC = 5'd11;
  localparam logic [4:0] C_RRC = 5'd12, C_RAL = 5'd13, C_RAR = 5'd14, C_STC = 5'd15;
  localparam logic [4:0] C_CMC = 5'd16, C_DAA = 5'd17, C_DAD = 5'd18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [7:0]  operand = '0;
  logic [15:0] pair_hl = '0, pair_rp = '0;
  logic [7:0]  acc_q;
  logic [4:0]  flags_q;
  logic [15:0] pair_q;

  alu8_acc_core #(.DATA_W(8)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .pair_hl(pair_hl), .pair_rp(pair_rp),
    .acc_q(acc_q), .flags_q(flags_q), .pair_q(pair_q)
  );

  always #4 clk = ~clk;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic done    = 1'b0;

  logic [7:0]  m_acc  = '0;
  logic [4:0]  m_fl   = '0;
  logic [15:0] m_pair = '0;

  function automatic string tag_of(logic v, logic [4:0] op);
    if (!v || op > C_DAD) return "R2";
    case (op)
      C_ADD, C_ADC: return "R3/R7";
      C_SUB, C_SBB: return "R4/R7";
      C_AND, C_OR, C_XOR: return "R5/R7";
      C_CMP: return "R6";
      C_INC, C_DEC: return "R8/R7";
      C_RLC, C_RRC, C_RAL, C_RAR: return "R9";
      C_CMA, C_STC, C_CMC: return "R10";
      C_DAA: return "R11/R7";
      default: return "R12";
    endcase
  endfunction

  task automatic model_step(logic [4:0] op, logic [7:0] b, logic [15:0] hl, logic [15:0] rp);
    int a, bi, c, s, t, lo;
    logic cy, ac, nc, nac, upd, wr, lofix, hifix;
    logic [7:0] r;
    a = int'(m_acc); bi = int'(b);
    cy = m_fl[0]; ac = m_fl[2];
    nc = cy; nac = ac; upd = 1'b0; wr = 1'b0; r = m_acc;
    case (op)
      C_ADD, C_ADC: begin
        c = (op == C_ADC) ? int'(cy) : 0;
        s = a + bi + c;
        r = 8'(s); nc = (s > 255); nac = ((a % 16) + (bi % 16) + c) > 15;
        upd = 1'b1; wr = 1'b1;
      end
      C_SUB, C_SBB, C_CMP: begin
        c = (op == C_SBB) ? int'(cy) : 0;
        s = a - bi - c;
        r = 8'((s + 512) % 256); nc = (s < 0); nac = ((a % 16) - (bi % 16) - c) < 0;
        upd = 1'b1; wr = (op != C_CMP);
      end
      C_AND: begin r = m_acc & b; nc = 1'b0; nac = 1'b0; upd = 1'b1; wr = 1'b1; end
      C_OR:  begin r = m_acc | b; nc = 1'b0; nac = 1'b0; upd = 1'b1; wr = 1'b1; end
      C_XOR: begin r = m_acc ^ b; nc = 1'b0; nac = 1'b0; upd = 1'b1; wr = 1'b1; end
      C_INC: begin r = 8'((a + 1) % 256); nac = (a % 16) == 15; upd = 1'b1; wr = 1'b1; end
      C_DEC: begin r = 8'((a + 255) % 256); nac = (a % 16) == 0; upd = 1'b1; wr = 1'b1; end
      C_CMA: begin r = ~m_acc; wr = 1'b1; end
      C_RLC: begin r = {m_acc[6:0], m_acc[7]}; nc = m_acc[7]; wr = 1'b1; end
      C_RRC: begin r = {m_acc[0], m_acc[7:1]}; nc = m_acc[0]; wr = 1'b1; end
      C_RAL: begin r = {m_acc[6:0], cy}; nc = m_acc[7]; wr = 1'b1; end
      C_RAR: begin r = {cy, m_acc[7:1]}; nc = m_acc[0]; wr = 1'b1; end
      C_STC: nc = 1'b1;
      C_CMC: nc = ~cy;
      C_DAA: begin
        lofix = ((a % 16) > 9) || ac;
        lo = lofix ? 6 : 0;
        t = a + lo;
        nac = ((a % 16) + lo) > 15;
        hifix = (((t / 16) % 16) > 9) || cy || (t > 255);
        r = 8'((t + (hifix ? 96 : 0)) % 256);
        nc = hifix; upd = 1'b1; wr = 1'b1;
      end
      C_DAD: begin
        s = int'(hl) + int'(rp);
        m_pair = 16'(s % 65536); nc = (s > 65535);
      end
      default: ;
    endcase
    if (upd) m_fl = {r[7], (r == 8'h00), nac, ~^r, nc};
    else     m_fl = {m_fl[4], m_fl[3], nac, m_fl[1], nc};
    if (wr) m_acc = r;
  endtask

  task automatic check_state(string tag);
    n_tests++;
    if (acc_q !== m_acc || flags_q !== m_fl || pair_q !== m_pair) begin
      n_fail++;
      $display("FAIL %s: acc=%h flags=%b pair=%h expected acc=%h flags=%b pair=%h",
               tag, acc_q, flags_q, pair_q, m_acc, m_fl, m_pair);
    end
  endtask

  task automatic check_val(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register it, compare at the next falling edge.
  task automatic step(logic v, logic [4:0] op, logic [7:0] b,
                      logic [15:0] hl = 16'h0000, logic [15:0] rp = 16'h0000);
    op_valid = v; op_code = op; operand = b; pair_hl = hl; pair_rp = rp;
    if (v) model_step(op, b, hl, rp);
    @(negedge clk);
    check_state(tag_of(v, op));
  endtask

  task automatic load_acc(logic [7:0] val);
    step(1'b1, C_AND, 8'h00);
    step(1'b1, C_ADD, val);
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [7:0]  bv;
    logic [4:0]  rop;
    // R1: reset clears everything even with an operation presented
    op_valid = 1'b1; op_code = C_ADD; operand = 8'h55;
    repeat (3) @(negedge clk);
    check_state("R1");
    rst = 1'b0; op_valid = 1'b0;

    // R11: worked BCD example
    load_acc(8'h39);
    step(1'b1, C_ADD, 8'h12);
    check_val("R11", {8'h00, acc_q}, 16'h004B);
    step(1'b1, C_DAA, 8'h00);
    check_val("R11", {8'h00, acc_q}, 16'h0051);
    check_val("R11", {15'h0, flags_q[0]}, 16'h0000);

    // R6: three compare outcomes, accumulator 0x40
    load_acc(8'h40);
    step(1'b1, C_CMP, 8'h30);
    check_val("R6", {14'h0, flags_q[3], flags_q[0]}, 16'h0000);
    step(1'b1, C_CMP, 8'h40);
    check_val("R6", {14'h0, flags_q[3], flags_q[0]}, 16'h0002);
    step(1'b1, C_CMP, 8'h50);
    check_val("R6", {14'h0, flags_q[3], flags_q[0]}, 16'h0001);
    check_val("R6", {8'h00, acc_q}, 16'h0040);

    // R2: idle cycles and undefined codes change nothing
    step(1'b0, C_ADD, 8'hFF);
    step(1'b0, C_DAD, 8'h00, 16'hFFFF, 16'h0001);
    for (int k = 19; k < 32; k++) step(1'b1, 5'(k), 8'hA5, 16'h1234, 16'h4321);
    check_val("R2", {8'h00, acc_q}, 16'h0040);

    // R3 R4 R5 R6: binary ops over every accumulator value, both carry-ins
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 4; bi++) begin
          case (bi)
            0: bv = 8'h00;
            1: bv = 8'h0F;
            2: bv = 8'hFF;
            default: bv = 8'(a);
          endcase
          for (int ci = 0; ci < 2; ci++) begin
            load_acc(8'(a));
            if (ci == 1) step(1'b1, C_STC, 8'h00);
            step(1'b1, 5'(op), bv);
          end
        end
      end
    end

    // R8 R9 R10: unary ops over every accumulator value, both carry states
    for (int u = 0; u < 8; u++) begin
      case (u)
        0: rop = C_INC; 1: rop = C_DEC; 2: rop = C_CMA; 3: rop = C_RLC;
        4: rop = C_RRC; 5: rop = C_RAL; 6: rop = C_RAR; default: rop = C_CMC;
      endcase
      for (int a = 0; a < 256; a++) begin
        for (int ci = 0; ci < 2; ci++) begin
          load_acc(8'(a));
          if (ci == 1) step(1'b1, C_STC, 8'h00);
          step(1'b1, rop, 8'h00);
        end
      end
    end

    // R11: decimal adjust after real additions (covers half carry, carry, overflow)
    for (int a = 0; a < 256; a++) begin
      for (int bi = 0; bi < 8; bi++) begin
        load_acc(8'(a));
        step(1'b1, C_ADD, 8'(bi * 37 + 1));
        step(1'b1, C_DAA, 8'h00);
      end
    end

    // R12: pair add, including the carry out of bit 15
    step(1'b1, C_DAD, 8'h00, 16'hFFFF, 16'h0001);
    check_val("R12", pair_q, 16'h0000);
    check_val("R12", {15'h0, flags_q[0]}, 16'h0001);
    step(1'b1, C_DAD, 8'h00, 16'h1234, 16'h1111);
    check_val("R12", pair_q, 16'h2345);

    // mixed pseudo-random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] != 4'h0, 5'(int'(lfsr[9:4]) % 22), lfsr[15:8],
           {lfsr[7:0], lfsr[15:8]}, lfsr ^ 16'h5A5A);
    end

    // R1: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    m_acc = '0; m_fl = '0; m_pair = '0;
    check_state("R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule